// File: doc/BRIEF.md
# Multi-Function Arithmetic, Logic and Shift Unit

This unit is the computing element of a 16-bit single-bus datapath. It receives an A operand, a high operand AH, a B operand taken from the internal bus, a 5-bit shift amount and a 4-bit function select. It produces a 16-bit low result C and a 16-bit high result CH. Both results are registered and hold their values between operations.

The control sequencer raises `start` for one cycle with a function selected. Every function except division completes on the next clock edge. Division runs as a restoring divider of fixed length and finishes 16 cycles after it is accepted. A one-cycle `done` pulse marks each completion. Multiply and divide use C and CH as a pair: the product is split high and low across them, and the quotient and remainder go to C and CH. NOT and increment-by-two act on the B operand so that the program counter can be stepped through the unit.

Top module: `alsu_unit`

## Requirements
- R1: While `rst_n` is low and after its release, `c`, `ch`, `done` and `div_err` are all zero until the first completed operation.
- R2: Add (func 0) gives C = A+B modulo 2^16, and subtract (func 1) gives C = A-B modulo 2^16. Both leave CH unchanged and pulse `done` in the cycle after the accepted `start`.
- R3: AND (func 4) gives C = A&B, OR (func 5) gives A|B, NOT (func 6) gives ~B, pass (func 10) gives B, and increment (func 11) gives B+2 modulo 2^16. All of them leave CH unchanged.
- R4: Multiply (func 2) treats A and B as unsigned and writes the 32-bit product with bits 31..16 in CH and bits 15..0 in C.
- R5: The shifts move A by the 5-bit amount n, from 0 to 31, and leave CH unchanged. Left shift (func 7) fills with zeros. Logical right shift (func 8) fills with zeros. Arithmetic right shift (func 9) fills with bit 15 of A. A count of 16 or more moves every bit out.
- R6: Divide (func 3) with AH < B treats {AH,A} as an unsigned dividend. It writes the quotient to C and the remainder to CH. `done` rises 16 clock edges after the edge that sampled `start`, and `div_err` is 0.
- R7: Divide with B = 0, or any divide whose quotient would not fit in 16 bits (AH >= B), writes 0xFFFF to C and A to CH and sets `div_err`. It uses the same 16-cycle latency.
- R8: `div_err` changes only when `done` is pulsed. Any completed operation other than a failed divide clears it.
- R9: A `start` raised while a divide is in progress is ignored. C and CH keep their values, and no extra `done` pulse appears.
- R10: `done` is high for exactly one cycle per completed operation. C and CH change only in a cycle where `done` is high. Function codes 12 to 15 complete with `done` but leave C and CH unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the selected function this cycle |
| func | input | 4 | Function select code |
| a | input | 16 | A operand, low half of the dividend |
| ah | input | 16 | High half of the dividend |
| b | input | 16 | B operand from the internal bus |
| shamt | input | 5 | Shift amount n |
| c | output | 16 | Low result |
| ch | output | 16 | High result |
| done | output | 1 | One-cycle completion pulse |
| div_err | output | 1 | Last divide failed (zero divisor or quotient overflow) |

## Verification
A wrong partial remainder in the divider is never exposed while the divider runs. It appears only as a wrong quotient or remainder on C and CH at the completion pulse, 16 cycles after start. For that reason the divide tests pair a chosen dividend and divisor whose every quotient bit is exercised, and the bench compares both halves. An off-by-one in the step counter moves the `done` pulse by a cycle. The bench catches this by checking that `done` is low one cycle early and high on the expected cycle. A select decode error shows on C or CH in the cycle right after start.

// File: rtl/alsu_pkg.sv
package alsu_pkg;
    typedef enum logic [3:0] {
        FN_ADD  = 4'd0,
        FN_SUB  = 4'd1,
        FN_MUL  = 4'd2,
        FN_DIV  = 4'd3,
        FN_AND  = 4'd4,
        FN_OR   = 4'd5,
        FN_NOT  = 4'd6,
        FN_SHL  = 4'd7,
        FN_SHR  = 4'd8,
        FN_ASR  = 4'd9,
        FN_PASS = 4'd10,
        FN_INC2 = 4'd11
    } alsu_fn_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RIGHT = 2'd1,
        SH_ARITH = 2'd2
    } shift_mode_e;
endpackage

// File: rtl/alsu_shifter.sv
module alsu_shifter
    import alsu_pkg::*;
#(
    parameter int W  = 16,
    parameter int SW = 5
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    input  shift_mode_e   mode,
    output logic [W-1:0]  dout
);
    logic [W-1:0] stg [0:SW];
    logic         left;
    logic         fill;

    assign left   = (mode == SH_LEFT);
    assign fill   = (mode == SH_ARITH) ? din[W-1] : 1'b0;
    assign stg[0] = din;

    for (genvar i = 0; i < SW; i++) begin : g_stage
        localparam int D = 1 << i;
        if (D >= W) begin : g_flush
            assign stg[i+1] = amt[i] ? (left ? '0 : {W{fill}}) : stg[i];
        end else begin : g_move
            assign stg[i+1] = amt[i]
                ? (left ? {stg[i][W-1-D:0], {D{1'b0}}}
                        : {{D{fill}}, stg[i][W-1:D]})
                : stg[i];
        end
    end

    assign dout = stg[SW];
endmodule

// File: rtl/alsu_divider.sv
module alsu_divider #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dvd_hi,
    input  logic [W-1:0] dvd_lo,
    input  logic [W-1:0] dvs,
    output logic         busy,
    output logic         fin,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem,
    output logic         err
);
    localparam int CW = $clog2(W);

    typedef struct packed {
        logic         busy;
        logic         err;
        logic [CW-1:0] cnt;
        logic [W-1:0] rem;
        logic [W-1:0] quo;
        logic [W-1:0] dvs;
    } div_state_t;

    div_state_t s_d, s_q;
    logic [W:0]   trial;
    logic         fits;
    logic [W-1:0] rem_nx;
    logic [W-1:0] quo_nx;
    logic         last;

    always_comb begin
        trial  = {s_q.rem, s_q.quo[W-1]};
        fits   = trial >= {1'b0, s_q.dvs};
        rem_nx = fits ? W'(trial - {1'b0, s_q.dvs}) : trial[W-1:0];
        quo_nx = {s_q.quo[W-2:0], fits};
        last   = s_q.busy && (s_q.cnt == CW'(W-1));

        s_d = s_q;
        if (go && !s_q.busy) begin
            s_d.busy = 1'b1;
            s_d.err  = (dvd_hi >= dvs);
            s_d.cnt  = '0;
            s_d.rem  = dvd_hi;
            s_d.quo  = dvd_lo;
            s_d.dvs  = dvs;
        end else if (s_q.busy) begin
            s_d.cnt = s_q.cnt + CW'(1);
            if (!s_q.err) begin
                s_d.rem = rem_nx;
                s_d.quo = quo_nx;
            end
            if (last) begin
                s_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = s_q.busy;
    assign fin  = last;
    assign err  = s_q.err;
    assign quo  = s_q.err ? {W{1'b1}} : quo_nx;
    assign rem  = s_q.err ? s_q.quo : rem_nx;

    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !s_q.err) |-> (s_q.rem < s_q.dvs)); // R6
    AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !last) |=> s_q.busy); // R9
endmodule

// File: rtl/alsu_unit.sv
module alsu_unit
    import alsu_pkg::*;
#(
    parameter int W  = 16,
    parameter int SW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    func,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  ah,
    input  logic [W-1:0]  b,
    input  logic [SW-1:0] shamt,
    output logic [W-1:0]  c,
    output logic [W-1:0]  ch,
    output logic          done,
    output logic          div_err
);
    localparam int PW = 2 * W;

    typedef struct packed {
        logic [W-1:0] c;
        logic [W-1:0] ch;
        logic         done;
        logic         err;
    } out_state_t;

    out_state_t   s_d, s_q;
    alsu_fn_e     fn;
    shift_mode_e  sh_mode;
    logic [W-1:0] sh_out;
    logic [PW-1:0] prod;
    logic         accept;
    logic         div_go;
    logic         div_busy;
    logic         div_fin;
    logic         div_fail;
    logic [W-1:0] div_quo;
    logic [W-1:0] div_rem;

    assign fn     = alsu_fn_e'(func);
    assign accept = start && !div_busy;
    assign div_go = accept && (fn == FN_DIV);
    assign prod   = {{W{1'b0}}, a} * {{W{1'b0}}, b};

    always_comb begin
        case (fn)
            FN_SHL:  sh_mode = SH_LEFT;
            FN_ASR:  sh_mode = SH_ARITH;
            default: sh_mode = SH_RIGHT;
        endcase
    end

    alsu_shifter #(.W(W), .SW(SW)) u_shift (
        .din  (a),
        .amt  (shamt),
        .mode (sh_mode),
        .dout (sh_out)
    );

    alsu_divider #(.W(W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (div_go),
        .dvd_hi (ah),
        .dvd_lo (a),
        .dvs    (b),
        .busy   (div_busy),
        .fin    (div_fin),
        .quo    (div_quo),
        .rem    (div_rem),
        .err    (div_fail)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (div_fin) begin
            s_d.c    = div_quo;
            s_d.ch   = div_rem;
            s_d.err  = div_fail;
            s_d.done = 1'b1;
        end else if (accept && fn != FN_DIV) begin
            s_d.done = 1'b1;
            s_d.err  = 1'b0;
            case (fn)
                FN_ADD:  s_d.c = a + b;
                FN_SUB:  s_d.c = a - b;
                FN_MUL:  {s_d.ch, s_d.c} = prod;
                FN_AND:  s_d.c = a & b;
                FN_OR:   s_d.c = a | b;
                FN_NOT:  s_d.c = ~b;
                FN_SHL, FN_SHR, FN_ASR: s_d.c = sh_out;
                FN_PASS: s_d.c = b;
                FN_INC2: s_d.c = b + W'(2);
                default: s_d.c = s_q.c;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign c       = s_q.c;
    assign ch      = s_q.ch;
    assign done    = s_q.done;
    assign div_err = s_q.err;

    AST_HOLD_BETWEEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !s_d.done |=> ($stable(c) && $stable(ch))); // R10
    AST_ERR_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !s_d.done |=> $stable(div_err)); // R8
    AST_ADD_KEEPS_CH: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && fn == FN_ADD) |=> (done && $stable(ch))); // R2
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start && div_busy && !div_fin) |=> !done); // R9
endmodule

// File: tb/tb_alsu_unit.sv
module tb_alsu_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  func = '0;
    logic [15:0] a = '0, ah = '0, b = '0;
    logic [4:0]  shamt = '0;
    logic [15:0] c, ch;
    logic        done, div_err;

    int checks = 0;
    int errors = 0;
    logic [15:0] m_c = '0, m_ch = '0;

    always #4 clk = ~clk;

    alsu_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .func(func),
        .a(a), .ah(ah), .b(b), .shamt(shamt),
        .c(c), .ch(ch), .done(done), .div_err(div_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic single_op(input string tag, input logic [3:0] f, input logic [15:0] va,
                             input logic [15:0] vb, input logic [4:0] n,
                             input logic [15:0] ec, input logic [15:0] ech);
        func = f; a = va; b = vb; shamt = n; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({tag, " done"}, {31'd0, done}, 32'd1);
        check({tag, " c"}, {16'd0, c}, {16'd0, ec});
        check({tag, " ch"}, {16'd0, ch}, {16'd0, ech});
        check({tag, " err"}, {31'd0, div_err}, 32'd0);
        m_c = ec; m_ch = ech;
        @(negedge clk);
        check({tag, " done pulse R10"}, {31'd0, done}, 32'd0);
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset", {c, ch}, 32'd0);
        check("R1 flags", {30'd0, done, div_err}, 32'd0);
    endtask

    task automatic test_arith();
        single_op("R2 add", 4'd0, 16'hFFF0, 16'h0015, 5'd0, 16'h0005, m_ch);
        single_op("R2 sub", 4'd1, 16'h0003, 16'h0005, 5'd0, 16'hFFFE, m_ch);
    endtask

    task automatic test_logic();
        single_op("R4 mul", 4'd2, 16'hFFFF, 16'hFFFF, 5'd0, 16'h0001, 16'hFFFE);
        single_op("R3 and", 4'd4, 16'hF0F0, 16'h3C3C, 5'd0, 16'h3030, m_ch);
        single_op("R3 or",  4'd5, 16'hF0F0, 16'h0C0C, 5'd0, 16'hFCFC, m_ch);
        single_op("R3 not", 4'd6, 16'h1234, 16'h00FF, 5'd0, 16'hFF00, m_ch);
        single_op("R3 pass", 4'd10, 16'h1111, 16'hBEEF, 5'd0, 16'hBEEF, m_ch);
        single_op("R3 inc2", 4'd11, 16'h0000, 16'hFFFF, 5'd0, 16'h0001, m_ch);
        single_op("R4 mul2", 4'd2, 16'd300, 16'd500, 5'd0, 16'(32'd150000), 16'(32'd150000 >> 16));
    endtask

    task automatic test_shift();
        logic [15:0] v = 16'h9A51;
        for (int n = 0; n < 32; n += 5) begin
            single_op("R5 shl", 4'd7, v, 16'h0, 5'(n), v << n, m_ch);
            single_op("R5 shr", 4'd8, v, 16'h0, 5'(n), v >> n, m_ch);
            single_op("R5 asr", 4'd9, v, 16'h0, 5'(n), 16'($signed(v) >>> n), m_ch);
        end
        single_op("R5 asr16", 4'd9, 16'h8000, 16'h0, 5'd16, 16'hFFFF, m_ch);
    endtask

    task automatic div_op(input string tag, input logic [15:0] vh, input logic [15:0] vl,
                          input logic [15:0] vb, input logic poke);
        logic [31:0] dvd = {vh, vl};
        logic [15:0] eq, er;
        logic        ee = (vh >= vb);
        eq = ee ? 16'hFFFF : 16'(dvd / {16'd0, vb});
        er = ee ? vl : 16'(dvd % {16'd0, vb});
        func = 4'd3; ah = vh; a = vl; b = vb; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k < 16; k++) begin
            if (poke && k == 5) begin
                func = 4'd0; start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            if (k == 6) check({tag, " R9 ignored c"}, {16'd0, c}, {16'd0, m_c});
            if (k == 15) check({tag, " R6 early done"}, {31'd0, done}, 32'd0);
            if (poke && k == 6) check({tag, " R9 no done"}, {31'd0, done}, 32'd0);
        end
        @(negedge clk);
        check({tag, " done"}, {31'd0, done}, 32'd1);
        check({tag, " quo"}, {16'd0, c}, {16'd0, eq});
        check({tag, " rem"}, {16'd0, ch}, {16'd0, er});
        check({tag, " err"}, {31'd0, div_err}, {31'd0, ee});
        m_c = eq; m_ch = er;
        @(negedge clk);
        check({tag, " R10 pulse"}, {31'd0, done}, 32'd0);
    endtask

    task automatic test_div();
        div_op("R6 div", 16'h0012, 16'h3456, 16'h0100, 1'b0);
        div_op("R6 div big", 16'hFFFE, 16'hFFFF, 16'hFFFF, 1'b1);
        div_op("R7 div zero", 16'h0000, 16'h4321, 16'h0000, 1'b0);
        check("R7 err held", {31'd0, div_err}, 32'd1);
        div_op("R7 overflow", 16'h0100, 16'h0007, 16'h0100, 1'b0);
        single_op("R8 clear", 4'd0, 16'd1, 16'd2, 5'd0, 16'd3, m_ch);
    endtask

    task automatic test_undef();
        func = 4'd13; a = 16'hAAAA; b = 16'h5555; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10 undef done", {31'd0, done}, 32'd1);
        check("R10 undef hold", {c, ch}, {m_c, m_ch});
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R10 actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        test_reset();
        test_arith();
        test_logic();
        test_shift();
        test_div();
        test_undef();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule